// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block turns activity on a wide set of general-purpose input ports into processor interrupts through eight shared interrupt groups. Each group picks one input bit through a 4-bit selector, detects a programmed condition on it (a level or an edge), and latches that event into a pending bit. The pending bits are gated by a per-group enable and ORed into one registered interrupt line.

Software sets up the trigger codes, the pin selectors and the enables through a small word-addressed register port. An interrupt handler reads the masked status to find which groups fired, then clears them by writing ones to the acknowledge word. Inputs are asynchronous to the block clock and pass through a two-stage synchronizer before any detection takes place.

Top module: `gpirq_top`

## Requirements
- R1: After reset, the trigger word, the selector word, the enable word, the pending bits and `irq_o` all read as zero.
- R2: The register port decodes address 0 as the trigger word (group g uses bits [3g+2:3g]), address 1 as the selector word (group g uses bits [4g+3:4g]) and address 2 as the enable word (bit g for group g). Each reads back the value last written. Address 3 is the write-one acknowledge word and reads as zero. Address 4 holds the pending bits and address 5 the masked pending bits. Writes to addresses 4 and 5 are ignored.
- R3: Trigger code 5 sets the pending bit on a 0-to-1 transition of the selected input and not on a 1-to-0 transition.
- R4: Trigger code 6 sets the pending bit on a 1-to-0 transition and not on a 0-to-1 transition.
- R5: Trigger code 7 sets the pending bit on a transition in either direction.
- R6: Trigger code 4 (active high) and code 3 (active low) keep the pending bit set while the input is at its active level, so an acknowledge does not clear it then. Once the level has gone, an acknowledge clears it.
- R7: Trigger codes 0, 1 and 2 never set the pending bit, whatever the input does.
- R8: A selector value s picks port s/4 and byte lane s%4. Group g then watches bit g of that lane, which is port bit 8*(s%4)+g. Activity on any other bit does not affect the group.
- R9: Writing 1 to bit g of the acknowledge word clears pending bit g. Writing 0 leaves it unchanged.
- R10: The masked status equals the pending bits ANDed with the enable word. `irq_o` is high exactly one cycle after the masked status is non-zero.
- R11: If a new trigger event and an acknowledge for the same group fall in the same cycle, the pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| port_in | input | NUM_PORTS*32 | Input ports, port p at bits [32p+31:32p] |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Registered OR of the masked pending bits |

## Verification
The hardest case to reach from the ports is the collision in R11: the acknowledge write has to land in exactly the cycle in which the synchronized edge reaches the detector. The bench counts the two synchronizer stages from the input change and asserts the acknowledge strobe so that it is sampled on the same clock edge that latches the new event. It then reads the pending word to check that the bit survived. Level modes are covered by acknowledging while the level is held and again after it is removed.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;
  localparam int NGROUP  = 8;
  localparam int TRG_W   = 3;
  localparam int SEL_W   = 4;
  localparam int LANE_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 32;

  localparam logic [TRG_W-1:0] TRG_LVL_LO = 3'd3;
  localparam logic [TRG_W-1:0] TRG_LVL_HI = 3'd4;
  localparam logic [TRG_W-1:0] TRG_RISE   = 3'd5;
  localparam logic [TRG_W-1:0] TRG_FALL   = 3'd6;
  localparam logic [TRG_W-1:0] TRG_BOTH   = 3'd7;

  localparam logic [ADDR_W-1:0] A_TRIG   = 3'd0;
  localparam logic [ADDR_W-1:0] A_SEL    = 3'd1;
  localparam logic [ADDR_W-1:0] A_ENA    = 3'd2;
  localparam logic [ADDR_W-1:0] A_ACK    = 3'd3;
  localparam logic [ADDR_W-1:0] A_PEND   = 3'd4;
  localparam logic [ADDR_W-1:0] A_MPEND  = 3'd5;
endpackage

// File: rtl/gpirq_regs.sv
module gpirq_regs
  import gpirq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [NGROUP-1:0]        pend,
  output logic [NGROUP*TRG_W-1:0]  trig_cfg,
  output logic [NGROUP*SEL_W-1:0]  sel_cfg,
  output logic [NGROUP-1:0]        ena,
  output logic [NGROUP-1:0]        ack,
  output logic [DATA_W-1:0]        rdata
);
  localparam int TW = NGROUP*TRG_W;
  localparam int SW = NGROUP*SEL_W;

  logic [TW-1:0]     trig_d;
  logic [SW-1:0]     sel_d;
  logic [NGROUP-1:0] ena_d;
  logic              trig_en, sel_en, ena_en;

  always_comb begin
    trig_en = we && (addr == A_TRIG);
    sel_en  = we && (addr == A_SEL);
    ena_en  = we && (addr == A_ENA);
    trig_d  = trig_en ? wdata[TW-1:0] : trig_cfg;
    sel_d   = sel_en  ? wdata[SW-1:0] : sel_cfg;
    ena_d   = ena_en  ? wdata[NGROUP-1:0] : ena;
    ack     = (we && (addr == A_ACK)) ? wdata[NGROUP-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_cfg <= '0;
      sel_cfg  <= '0;
      ena      <= '0;
    end else begin
      trig_cfg <= trig_d;
      sel_cfg  <= sel_d;
      ena      <= ena_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_TRIG:  rdata[TW-1:0]     = trig_cfg;
      A_SEL:   rdata[SW-1:0]     = sel_cfg;
      A_ENA:   rdata[NGROUP-1:0] = ena;
      A_PEND:  rdata[NGROUP-1:0] = pend;
      A_MPEND: rdata[NGROUP-1:0] = pend & ena;
      default: rdata = '0;
    endcase
  end

  p_ena_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == A_ENA) |=> $stable(ena));
endmodule

// File: rtl/gpirq_group.sv
module gpirq_group
  import gpirq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32,
  parameter int GRP_IDX   = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*PORT_W-1:0] ports,
  input  logic [SEL_W-1:0]            sel,
  input  logic [TRG_W-1:0]            mode,
  input  logic                        ack,
  output logic                        pending
);
  localparam int LANES = PORT_W / LANE_W;

  logic pin_raw, sync1, sync2, sync_prev, hit, pend_d;

  always_comb begin
    pin_raw = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      for (int l = 0; l < LANES; l++) begin
        if (sel == SEL_W'(p*4 + l))
          pin_raw = ports[p*PORT_W + l*LANE_W + GRP_IDX];
      end
    end
  end

  always_comb begin
    case (mode)
      TRG_LVL_LO: hit = !sync2;
      TRG_LVL_HI: hit = sync2;
      TRG_RISE:   hit = sync2 && !sync_prev;
      TRG_FALL:   hit = !sync2 && sync_prev;
      TRG_BOTH:   hit = sync2 ^ sync_prev;
      default:    hit = 1'b0;
    endcase
    pend_d = hit || (pending && !ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1     <= 1'b0;
      sync2     <= 1'b0;
      sync_prev <= 1'b0;
      pending   <= 1'b0;
    end else begin
      sync1     <= pin_raw;
      sync2     <= sync1;
      sync_prev <= sync2;
      pending   <= pend_d;
    end
  end

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !hit) |=> !pending);
  p_event_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && hit) |=> pending);
  p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode < TRG_LVL_LO && !pending) |=> !pending);
endmodule

// File: rtl/gpirq_top.sv
module gpirq_top
  import gpirq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*PORT_W-1:0] port_in,
  input  logic                        reg_we,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  output logic                        irq_o
);
  logic                     rst_meta, rst_sync_n;
  logic [NGROUP*TRG_W-1:0]  trig_cfg;
  logic [NGROUP*SEL_W-1:0]  sel_cfg;
  logic [NGROUP-1:0]        ena, ack, pend, masked;
  logic                     irq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  gpirq_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .pend     (pend),
    .trig_cfg (trig_cfg),
    .sel_cfg  (sel_cfg),
    .ena      (ena),
    .ack      (ack),
    .rdata    (reg_rdata)
  );

  for (genvar g = 0; g < NGROUP; g++) begin : g_grp
    gpirq_group #(
      .NUM_PORTS (NUM_PORTS),
      .PORT_W    (PORT_W),
      .GRP_IDX   (g)
    ) u_grp (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .ports   (port_in),
      .sel     (sel_cfg[g*SEL_W +: SEL_W]),
      .mode    (trig_cfg[g*TRG_W +: TRG_W]),
      .ack     (ack[g]),
      .pending (pend[g])
    );
  end

  always_comb begin
    masked = pend & ena;
    irq_d  = |masked;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_o <= 1'b0;
    else             irq_o <= irq_d;
  end

  p_irq_low_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (masked == '0) |=> !irq_o);
  p_irq_high_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (masked != '0) |=> irq_o);
endmodule

// File: tb/gpirq_top_tb_top.sv
`timescale 1ns/1ps
module gpirq_top_tb_top;
  localparam int NP = 4;
  localparam int PW = 32;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NP*PW-1:0] pins = '0;
  logic           reg_we = 1'b0;
  logic [2:0]     reg_addr = '0;
  logic [31:0]    reg_wdata = '0;
  logic [31:0]    reg_rdata;
  logic           irq_o;
  logic           chk_en = 1'b0;
  item_t          q[$];
  int             checks = 0;
  int             errors = 0;
  bit             done = 1'b0;

  always #10 clk = ~clk;

  gpirq_top #(.NUM_PORTS(NP), .PORT_W(PW)) dut_i (
    .clk (clk), .rst_n (rst_n), .port_in (pins), .reg_we (reg_we),
    .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .irq_o (irq_o)
  );

  // monitor: pops expected items and compares away from the clock edge
  always @(negedge clk) begin
    if (chk_en && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = it.is_irq ? {31'b0, irq_o} : reg_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic expect_reg(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    @(posedge clk); #1;
    reg_addr = a; q.push_back(it); chk_en = 1'b1;
    @(posedge clk); #1;
    chk_en = 1'b0;
  endtask

  task automatic expect_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    @(posedge clk); #1;
    q.push_back(it); chk_en = 1'b1;
    @(posedge clk); #1;
    chk_en = 1'b0;
  endtask

  task automatic pin(input int i, input logic v);
    @(posedge clk); #1;
    pins[i] = v;
    cyc(5);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R1 reset state
    expect_reg(3'd0, 32'h0, "R1 trigger word");
    expect_reg(3'd1, 32'h0, "R1 selector word");
    expect_reg(3'd2, 32'h0, "R1 enable word");
    expect_reg(3'd4, 32'h0, "R1 pending");
    expect_irq(1'b0, "R1 irq");

    // R2 configuration: g0 rise, g1 fall, g2 both, g3 high, g4 low, g5 off, g6 code2, g7 code1
    wr(3'd0, 32'(5 | (6 << 3) | (7 << 6) | (4 << 9) | (3 << 12) | (2 << 18) | (1 << 21)));
    expect_reg(3'd0, 32'(5 | (6 << 3) | (7 << 6) | (4 << 9) | (3 << 12) | (2 << 18) | (1 << 21)), "R2 trigger readback");
    wr(3'd2, 32'hFF);
    expect_reg(3'd2, 32'hFF, "R2 enable readback");
    wr(3'd1, 32'h1234_5678);
    expect_reg(3'd1, 32'h1234_5678, "R2 selector readback");
    wr(3'd1, 32'h0);
    expect_reg(3'd3, 32'h0, "R2 ack reads zero");
    cyc(5);
    // level-low on group 4 with pins low
    expect_reg(3'd4, 32'h10, "R6 level low pending");
    wr(3'd4, 32'h0);
    expect_reg(3'd4, 32'h10, "R2 pending write ignored");
    expect_irq(1'b1, "R10 irq high");
    wr(3'd3, 32'hFF);
    expect_reg(3'd4, 32'h10, "R6 level low reasserts");
    pin(4, 1'b1);
    wr(3'd3, 32'h10);
    expect_reg(3'd4, 32'h0, "R6 level low cleared");
    cyc(2);
    expect_irq(1'b0, "R10 irq low");

    // R3 rising
    pin(0, 1'b1);
    expect_reg(3'd4, 32'h01, "R3 rise sets");
    wr(3'd3, 32'h01);
    pin(0, 1'b0);
    expect_reg(3'd4, 32'h00, "R3 fall ignored");
    // R4 falling
    pin(1, 1'b1);
    expect_reg(3'd4, 32'h00, "R4 rise ignored");
    pin(1, 1'b0);
    expect_reg(3'd4, 32'h02, "R4 fall sets");
    wr(3'd3, 32'h02);
    // R5 both
    pin(2, 1'b1);
    expect_reg(3'd4, 32'h04, "R5 rise sets");
    wr(3'd3, 32'h04);
    pin(2, 1'b0);
    expect_reg(3'd4, 32'h04, "R5 fall sets");
    wr(3'd3, 32'h04);
    // R6 level high
    pin(3, 1'b1);
    expect_reg(3'd4, 32'h08, "R6 level high sets");
    wr(3'd3, 32'h08);
    expect_reg(3'd4, 32'h08, "R6 level high reasserts");
    pin(3, 1'b0);
    wr(3'd3, 32'h08);
    expect_reg(3'd4, 32'h00, "R6 level high cleared");
    // R7 disabled codes
    pin(5, 1'b1); pin(6, 1'b1); pin(7, 1'b1);
    pin(5, 1'b0); pin(6, 1'b0); pin(7, 1'b0);
    expect_reg(3'd4, 32'h00, "R7 off codes quiet");

    // R9 ack zero has no effect
    pin(0, 1'b1);
    wr(3'd3, 32'h00);
    expect_reg(3'd4, 32'h01, "R9 zero ack ignored");
    // R10 masking
    wr(3'd2, 32'h02);
    cyc(2);
    expect_reg(3'd5, 32'h00, "R10 masked off");
    expect_reg(3'd4, 32'h01, "R10 raw kept");
    expect_irq(1'b0, "R10 irq masked");
    wr(3'd2, 32'h01);
    cyc(2);
    expect_reg(3'd5, 32'h01, "R10 masked on");
    expect_irq(1'b1, "R10 irq unmasked");
    wr(3'd3, 32'h01);
    expect_reg(3'd4, 32'h00, "R9 one ack clears");

    // R8 selector: group 0 -> port 2 lane 3, bit 88
    pin(0, 1'b0);
    wr(3'd3, 32'hFF);
    wr(3'd1, 32'd11);
    cyc(5);
    wr(3'd3, 32'h01);
    pin(0, 1'b1);
    pin(80, 1'b1);
    expect_reg(3'd4, 32'h00, "R8 other bits ignored");
    pin(88, 1'b1);
    expect_reg(3'd4, 32'h01, "R8 selected bit sets");
    wr(3'd3, 32'h01);

    // R11 collision on group 2 (both edges)
    pin(2, 1'b1);
    expect_reg(3'd4, 32'h04, "R11 setup pending");
    @(posedge clk); #1;
    pins[2] = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h04;
    @(posedge clk); #1;
    reg_we = 1'b0;
    expect_reg(3'd4, 32'h04, "R11 event beats ack");
    wr(3'd3, 32'h04);
    expect_reg(3'd4, 32'h00, "R11 cleared after");

    cyc(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule